// File: doc/BRIEF.md
# Segmented Buffer Three-Level Flow Status

This block keeps a free-segment counter for each logical FIFO carved out of one shared external segmented packet buffer of 8192 segments. The buffer is split evenly among 4, 8, 16, 32 or 64 FIFOs, chosen by a 3-bit select. A segment-allocate event lowers the counter of the FIFO it names. A segment-release event raises it. Both events carry a FIFO index.

From each counter the block derives a three-level flow-control status that a status-channel serialiser can poll. The levels are starving, hungry and satisfied. The hungry band is set by a programmable early-backpressure threshold. The satisfied band is set by a fixed low watermark of 6 segments. The early-backpressure band exists only while its enable bit is 1.

A combinational read port returns the status of any FIFO index. Two sticky flags record allocate and release events that were refused.

Top module: `segbuf_flow_status`

## Requirements
- R1: After reset or a change of the FIFO count, every active FIFO's free count equals 8192 divided by the FIFO count (128, 256, 512, 1024 or 2048).
- R2: The select maps 0 to 64 FIFOs, 1 to 32, 2 to 16, 3 to 8 and 4 to 4; the values 5, 6 and 7 mean 64. An index at or above the FIFO count is inactive: its status reads 10 and its events change nothing and raise no flag.
- R3: The status code is 00 for starving, 01 for hungry and 10 for satisfied; the code 11 never appears.
- R4: With the enable at 1, the status is starving when free is at or above the threshold, hungry when free is below the threshold but at least 6, and satisfied when free is below 6. A threshold of 0 therefore always gives starving.
- R5: With the enable at 0, the status is starving while free is non-zero and satisfied at zero; hungry is never reported, whatever the threshold.
- R6: An accepted allocate lowers the named FIFO's count by one and an accepted release raises it by one, at the clock edge; no other FIFO's count changes, and the status follows the count with no further delay.
- R7: An allocate and a release to the same FIFO at the same edge leave its count unchanged and raise no flag.
- R8: An allocate to a FIFO with zero free segments is ignored and sets the overflow flag, which stays set until reset.
- R9: A release to a FIFO whose count already equals its share is ignored and sets the underflow flag, which stays set until reset.
- R10: A change of the decoded FIFO count reloads every counter at the next clock edge; events at that edge are ignored, and the flags keep their values.
- R11: Reset (rst_n low, asynchronous) clears both flags; the counters take their share at the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fifo_sel | input | 3 | FIFO-count select |
| cfg_ebp_thr | input | 14 | Early-backpressure threshold in segments |
| cfg_ebp_en | input | 1 | Enables the hungry band |
| alloc_vld | input | 1 | Segment-allocate event |
| alloc_idx | input | 6 | FIFO index of the allocate |
| rel_vld | input | 1 | Segment-release event |
| rel_idx | input | 6 | FIFO index of the release |
| stat_idx | input | 6 | FIFO index to report |
| stat_code | output | 2 | Status of FIFO stat_idx |
| ovf_flag | output | 1 | Sticky refused-allocate flag |
| unf_flag | output | 1 | Sticky refused-release flag |

## Verification
The bench builds the block with its defaults: 8192 segments, at most 64 FIFOs, a low watermark of 6 and a 14-bit threshold. With these values each FIFO holds only 128 segments in the 64-FIFO setting, so a FIFO can be driven through every band, and past both ends of its count, in a few hundred cycles. The threshold can also reach one above the largest share. The bench uses this to read each setting's share through the threshold boundary, without draining 2048 segments.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;

   typedef enum logic [1:0] {
      ST_STARVE = 2'b00,
      ST_HUNGRY = 2'b01,
      ST_SATED  = 2'b10
   } seg_stat_e;

endpackage

// File: rtl/segbuf_cfg_decode.sv
module segbuf_cfg_decode #(
   parameter int TOTAL_SEGS = 8192,
   parameter int MAX_FIFOS  = 64,
   parameter int NSEL       = 5,
   parameter int SEL_W      = 3,
   parameter int CNT_W      = $clog2(TOTAL_SEGS + 1),
   parameter int FN_W       = $clog2(MAX_FIFOS) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             reload,
   output logic [CNT_W-1:0] load_share,
   output logic [CNT_W-1:0] cur_share,
   output logic [FN_W-1:0]  n_fifos
);
   localparam int SH_W = (NSEL > 1) ? $clog2(NSEL) : 1;
   localparam int BASE = TOTAL_SEGS / MAX_FIFOS;

   logic [SH_W-1:0] sh_dec;
   logic [SH_W-1:0] sh_q;
   logic            valid_q;

   always_comb begin
      if (int'(sel) < NSEL) sh_dec = SH_W'(sel);
      else                  sh_dec = '0;
   end

   assign reload     = !valid_q || (sh_dec != sh_q);
   assign load_share = CNT_W'(BASE) << sh_dec;
   assign cur_share  = CNT_W'(BASE) << sh_q;
   assign n_fifos    = FN_W'(MAX_FIFOS) >> sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q    <= '0;
         valid_q <= 1'b0;
      end else begin
         sh_q    <= sh_dec;
         valid_q <= 1'b1;
      end
   end
endmodule

// File: rtl/segbuf_free_ctr.sv
module segbuf_free_ctr #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] cur_share,
   input  logic             do_alloc,
   input  logic             do_rel,
   output logic [CNT_W-1:0] free_q,
   output logic             ovf_ev,
   output logic             unf_ev
);
   logic only_a;
   logic only_r;

   assign only_a = do_alloc && !do_rel && !reload;
   assign only_r = do_rel && !do_alloc && !reload;
   assign ovf_ev = only_a && (free_q == '0);
   assign unf_ev = only_r && (free_q >= cur_share);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q <= '0;
      end else if (reload) begin
         free_q <= load_val;
      end else if (only_a && !ovf_ev) begin
         free_q <= free_q - 1'b1;
      end else if (only_r && !unf_ev) begin
         free_q <= free_q + 1'b1;
      end
   end
endmodule

// File: rtl/segbuf_status_enc.sv
module segbuf_status_enc
   import segbuf_pkg::*;
#(
   parameter int CNT_W    = 14,
   parameter int LOW_MARK = 6
) (
   input  logic             active,
   input  logic [CNT_W-1:0] free_cnt,
   input  logic [CNT_W-1:0] thr,
   input  logic             ebp_en,
   output seg_stat_e        code
);
   always_comb begin
      if (!active)                         code = ST_SATED;
      else if (ebp_en) begin
         if (free_cnt >= thr)               code = ST_STARVE;
         else if (free_cnt >= CNT_W'(LOW_MARK)) code = ST_HUNGRY;
         else                               code = ST_SATED;
      end
      else if (free_cnt != '0)             code = ST_STARVE;
      else                                 code = ST_SATED;
   end
endmodule

// File: rtl/segbuf_flow_status.sv
module segbuf_flow_status
   import segbuf_pkg::*;
#(
   parameter int TOTAL_SEGS = 8192,
   parameter int MAX_FIFOS  = 64,
   parameter int NSEL       = 5,
   parameter int LOW_MARK   = 6,
   parameter int SEL_W      = 3,
   parameter int CNT_W      = $clog2(TOTAL_SEGS + 1),
   parameter int IDX_W      = $clog2(MAX_FIFOS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] cfg_fifo_sel,
   input  logic [CNT_W-1:0] cfg_ebp_thr,
   input  logic             cfg_ebp_en,
   input  logic             alloc_vld,
   input  logic [IDX_W-1:0] alloc_idx,
   input  logic             rel_vld,
   input  logic [IDX_W-1:0] rel_idx,
   input  logic [IDX_W-1:0] stat_idx,
   output logic [1:0]       stat_code,
   output logic             ovf_flag,
   output logic             unf_flag
);
   localparam int FN_W = IDX_W + 1;

   if (TOTAL_SEGS % MAX_FIFOS != 0) begin : g_bad_split
      $error("TOTAL_SEGS must divide evenly by MAX_FIFOS");
   end
   if ((MAX_FIFOS & (MAX_FIFOS - 1)) != 0) begin : g_bad_pow2
      $error("MAX_FIFOS must be a power of two");
   end
   if ((MAX_FIFOS >> (NSEL - 1)) < 1) begin : g_bad_nsel
      $error("NSEL gives a FIFO count below one");
   end
   if (LOW_MARK >= TOTAL_SEGS / MAX_FIFOS) begin : g_bad_low
      $error("LOW_MARK must be below the smallest share");
   end

   logic             reload;
   logic [CNT_W-1:0] load_share;
   logic [CNT_W-1:0] cur_share;
   logic [FN_W-1:0]  n_fifos;

   segbuf_cfg_decode #(
      .TOTAL_SEGS(TOTAL_SEGS), .MAX_FIFOS(MAX_FIFOS), .NSEL(NSEL),
      .SEL_W(SEL_W), .CNT_W(CNT_W), .FN_W(FN_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .sel(cfg_fifo_sel), .reload(reload),
      .load_share(load_share), .cur_share(cur_share), .n_fifos(n_fifos)
   );

   logic [CNT_W-1:0]     free_vec [MAX_FIFOS];
   logic [MAX_FIFOS-1:0] ovf_vec;
   logic [MAX_FIFOS-1:0] unf_vec;

   for (genvar i = 0; i < MAX_FIFOS; i++) begin : g_fifo
      logic act;
      logic hit_a;
      logic hit_r;
      assign act   = FN_W'(i) < n_fifos;
      assign hit_a = alloc_vld && (alloc_idx == IDX_W'(i)) && act;
      assign hit_r = rel_vld && (rel_idx == IDX_W'(i)) && act;

      segbuf_free_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .reload(reload), .load_val(load_share),
         .cur_share(cur_share), .do_alloc(hit_a), .do_rel(hit_r),
         .free_q(free_vec[i]), .ovf_ev(ovf_vec[i]), .unf_ev(unf_vec[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         unf_flag <= 1'b0;
      end else begin
         ovf_flag <= ovf_flag | (|ovf_vec);
         unf_flag <= unf_flag | (|unf_vec);
      end
   end

   logic      stat_act;
   seg_stat_e code;

   assign stat_act = {1'b0, stat_idx} < n_fifos;

   segbuf_status_enc #(.CNT_W(CNT_W), .LOW_MARK(LOW_MARK)) u_enc (
      .active(stat_act), .free_cnt(free_vec[stat_idx]), .thr(cfg_ebp_thr),
      .ebp_en(cfg_ebp_en), .code(code)
   );

   assign stat_code = code;
endmodule

// File: rtl/segbuf_flow_status_chk.sv
module segbuf_flow_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_ebp_en,
   input logic       alloc_vld,
   input logic       rel_vld,
   input logic [1:0] stat_code,
   input logic       ovf_flag,
   input logic       unf_flag
);
   assert_no_code3_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_code != 2'b11);

   assert_hungry_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_code == 2'b01) |-> cfg_ebp_en);

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(alloc_vld));

   assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      unf_flag |=> unf_flag);

   assert_unf_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unf_flag) |-> $past(rel_vld));
endmodule

bind segbuf_flow_status segbuf_flow_status_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_ebp_en(cfg_ebp_en), .alloc_vld(alloc_vld),
   .rel_vld(rel_vld), .stat_code(stat_code), .ovf_flag(ovf_flag),
   .unf_flag(unf_flag)
);

// File: tb/segbuf_flow_status_test.sv
module segbuf_flow_status_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_fifo_sel = '0;
   logic [13:0] cfg_ebp_thr = '0;
   logic        cfg_ebp_en = 1'b0;
   logic        alloc_vld = 1'b0;
   logic [5:0]  alloc_idx = '0;
   logic        rel_vld = 1'b0;
   logic [5:0]  rel_idx = '0;
   logic [5:0]  stat_idx = '0;
   logic [1:0]  stat_code;
   logic        ovf_flag;
   logic        unf_flag;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   segbuf_flow_status uut (
      .clk(clk), .rst_n(rst_n), .cfg_fifo_sel(cfg_fifo_sel),
      .cfg_ebp_thr(cfg_ebp_thr), .cfg_ebp_en(cfg_ebp_en),
      .alloc_vld(alloc_vld), .alloc_idx(alloc_idx), .rel_vld(rel_vld),
      .rel_idx(rel_idx), .stat_idx(stat_idx), .stat_code(stat_code),
      .ovf_flag(ovf_flag), .unf_flag(unf_flag)
   );

   typedef struct packed {
      logic [3:0]  req;
      logic [2:0]  sel;
      logic [13:0] thr;
      logic        en;
      logic [5:0]  idx;
      logic [1:0]  exp;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{4'd1,  3'd0, 14'd128,  1'b1, 6'd0,  2'b00},
      '{4'd1,  3'd0, 14'd129,  1'b1, 6'd0,  2'b01},
      '{4'd2,  3'd0, 14'd128,  1'b1, 6'd63, 2'b00},
      '{4'd1,  3'd1, 14'd256,  1'b1, 6'd0,  2'b00},
      '{4'd1,  3'd1, 14'd257,  1'b1, 6'd0,  2'b01},
      '{4'd2,  3'd1, 14'd256,  1'b1, 6'd31, 2'b00},
      '{4'd2,  3'd1, 14'd256,  1'b1, 6'd32, 2'b10},
      '{4'd1,  3'd2, 14'd512,  1'b1, 6'd15, 2'b00},
      '{4'd1,  3'd2, 14'd513,  1'b1, 6'd15, 2'b01},
      '{4'd1,  3'd3, 14'd1024, 1'b1, 6'd7,  2'b00},
      '{4'd1,  3'd3, 14'd1025, 1'b1, 6'd7,  2'b01},
      '{4'd1,  3'd4, 14'd2048, 1'b1, 6'd3,  2'b00},
      '{4'd1,  3'd4, 14'd2049, 1'b1, 6'd3,  2'b01},
      '{4'd2,  3'd4, 14'd2048, 1'b1, 6'd4,  2'b10},
      '{4'd2,  3'd5, 14'd129,  1'b1, 6'd63, 2'b01},
      '{4'd2,  3'd6, 14'd128,  1'b1, 6'd40, 2'b00},
      '{4'd2,  3'd7, 14'd129,  1'b1, 6'd0,  2'b01},
      '{4'd5,  3'd0, 14'd8000, 1'b0, 6'd0,  2'b00},
      '{4'd4,  3'd0, 14'd0,    1'b1, 6'd0,  2'b00},
      '{4'd3,  3'd0, 14'd8191, 1'b1, 6'd1,  2'b01}
   };

   task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic alloc(input logic [5:0] idx, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); alloc_vld = 1'b1; alloc_idx = idx;
         @(negedge clk); alloc_vld = 1'b0;
      end
   endtask

   task automatic release_seg(input logic [5:0] idx);
      @(negedge clk); rel_vld = 1'b1; rel_idx = idx;
      @(negedge clk); rel_vld = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      // R11 reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cfg_ebp_thr = 14'd100; cfg_ebp_en = 1'b1; stat_idx = 6'd0;
      #1;
      chk("R11 ovf after reset", {1'b0, ovf_flag}, 2'b00);
      chk("R11 unf after reset", {1'b0, unf_flag}, 2'b00);
      chk("R11 status after reset", stat_code, 2'b00);

      // table walk: R1 share, R2 mapping, R3 R4 R5 encoding
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         cfg_fifo_sel = VECS[v].sel; cfg_ebp_thr = VECS[v].thr;
         cfg_ebp_en = VECS[v].en;   stat_idx = VECS[v].idx;
         @(negedge clk); @(negedge clk);
         checks++;
         if (stat_code !== VECS[v].exp) begin
            fails++;
            $display("FAIL R%0d vector %0d: actual %b expected %b",
                     VECS[v].req, v, stat_code, VECS[v].exp);
         end
      end

      // directed band walk on FIFO 3 (64 FIFOs, share 128)
      @(negedge clk);
      cfg_fifo_sel = 3'd0; cfg_ebp_thr = 14'd100; cfg_ebp_en = 1'b1; stat_idx = 6'd3;
      alloc(6'd3, 28);
      chk("R4 free 100 at threshold", stat_code, 2'b00);
      alloc(6'd3, 1);
      chk("R4 free 99 below threshold", stat_code, 2'b01);
      alloc(6'd3, 93);
      chk("R4 free 6 at low mark", stat_code, 2'b01);
      alloc(6'd3, 1);
      chk("R4 free 5 below low mark", stat_code, 2'b10);
      stat_idx = 6'd4; #1;
      chk("R6 other FIFO untouched", stat_code, 2'b00);
      stat_idx = 6'd3; cfg_ebp_en = 1'b0; #1;
      chk("R5 disabled free 5", stat_code, 2'b00);
      alloc(6'd3, 5);
      chk("R5 disabled free 0", stat_code, 2'b10);
      chk("R8 no ovf yet", {1'b0, ovf_flag}, 2'b00);
      alloc(6'd3, 1);
      chk("R8 ovf set", {1'b0, ovf_flag}, 2'b01);
      chk("R8 count stays zero", stat_code, 2'b10);
      release_seg(6'd3);
      chk("R6 release to 1", stat_code, 2'b00);

      // R7 simultaneous allocate and release
      @(negedge clk); alloc_vld = 1'b1; alloc_idx = 6'd3; rel_vld = 1'b1; rel_idx = 6'd3;
      @(negedge clk); alloc_vld = 1'b0; rel_vld = 1'b0;
      chk("R7 count held at 1", stat_code, 2'b00);
      alloc(6'd3, 1);
      chk("R7 count was 1", stat_code, 2'b10);

      // R9 release at full share
      cfg_ebp_en = 1'b1; cfg_ebp_thr = 14'd129; stat_idx = 6'd5; #1;
      chk("R9 full before release", stat_code, 2'b01);
      release_seg(6'd5);
      chk("R9 unf set", {1'b0, unf_flag}, 2'b01);
      chk("R9 count stays 128", stat_code, 2'b01);
      alloc(6'd5, 1);
      chk("R8 ovf sticky", {1'b0, ovf_flag}, 2'b01);
      chk("R9 unf sticky", {1'b0, unf_flag}, 2'b01);

      // R10 count change reloads, event on that edge ignored
      cfg_ebp_thr = 14'd256; stat_idx = 6'd3;
      @(negedge clk); cfg_fifo_sel = 3'd1; alloc_vld = 1'b1; alloc_idx = 6'd3;
      @(negedge clk); alloc_vld = 1'b0;
      chk("R10 reload to 256", stat_code, 2'b00);
      chk("R10 ovf kept", {1'b0, ovf_flag}, 2'b01);
      chk("R10 unf kept", {1'b0, unf_flag}, 2'b01);

      // R11 reset clears flags; R2 inactive index events ignored
      do_reset();
      chk("R11 ovf cleared", {1'b0, ovf_flag}, 2'b00);
      chk("R11 unf cleared", {1'b0, unf_flag}, 2'b00);
      @(negedge clk); cfg_fifo_sel = 3'd4; cfg_ebp_thr = 14'd2048; stat_idx = 6'd3;
      @(negedge clk);
      chk("R1 share 2048 after change", stat_code, 2'b00);
      release_seg(6'd10);
      chk("R2 inactive release no unf", {1'b0, unf_flag}, 2'b00);
      alloc(6'd10, 1);
      stat_idx = 6'd10; #1;
      chk("R2 inactive status", stat_code, 2'b10);
      chk("R2 inactive alloc no ovf", {1'b0, ovf_flag}, 2'b00);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule